// File: doc/BRIEF.md
# Reset-Vectored Program Counter

This block holds the 20-bit byte address of the next instruction for a CPU front end. After reset it does not start at a fixed address. It first reads two bytes from memory locations 0 and 1 through a simple byte-read handshake and joins them into a 16-bit start address. The top four address bits are forced to zero. Only after both reads does it declare its output valid.

Once running, the counter advances by the byte length of each fetched instruction. That length is reported by the decoder and may be 1 to 6 bytes, and the addition wraps modulo 2^20. A branch strobe replaces the counter with a full 20-bit target, which may come from immediate data or from a register. Decode, the memory and interrupt vectoring stay outside the block.

Top module: `reset_vector_pc`

## Requirements
- R1: From reset until the vector sequence completes, `pc_valid` is 0 and `pc_out` reads zero.
- R2: The vector sequence drives `rd_req` high with `rd_addr` = 0 until a cycle with `rd_ack` high. It then drives `rd_req` high with `rd_addr` = 1 until the next `rd_ack`. `rd_data` is sampled in the cycle where `rd_ack` is high.
- R3: The vector is little-endian. The byte read from address 0 becomes `pc_out[7:0]` and the byte from address 1 becomes `pc_out[15:8]`. `pc_out[19:16]` is 0. `pc_valid` rises on the clock edge that accepts the second acknowledge.
- R4: While valid, `fetch_en` = 1 with `fetch_len` in 1..6 sets `pc_out` to (`pc_out` + `fetch_len`) mod 2^20 on the next edge.
- R5: While valid, `fetch_en` = 1 with `fetch_len` equal to 0 or 7 leaves `pc_out` unchanged.
- R6: While valid, `br_load` = 1 loads `br_target` into `pc_out` on the next edge.
- R7: When `br_load` and `fetch_en` are both high in one cycle, the branch target is loaded and the length is not added.
- R8: While valid, with neither `br_load` nor `fetch_en` high, `pc_out` holds its value.
- R9: `br_load`, `br_target`, `fetch_en` and `fetch_len` have no effect while the vector sequence is in progress.
- R10: Once `pc_valid` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Advance strobe for one fetched instruction |
| fetch_len | input | 3 | Byte length of the fetched instruction (1..6 accepted) |
| br_load | input | 1 | Branch strobe: load `br_target` |
| br_target | input | 20 | Branch target address |
| rd_req | output | 1 | Vector byte read request |
| rd_addr | output | 20 | Vector byte read address (0 or 1) |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Byte returned by memory |
| pc_out | output | 20 | Current program counter |
| pc_valid | output | 1 | Program counter holds a usable address |

## Verification
The assertions assume that memory raises `rd_ack` only while `rd_req` is high, and for exactly one cycle per byte. They also assume `br_target` and `fetch_len` are settled whenever their strobes are high. The bench's memory model enforces the handshake. It answers after a chosen latency and drops `rd_ack` as soon as it has been seen, so no request is acknowledged twice. The stimulus changes strobes and data only on the falling edge. It deliberately drives branch and advance strobes during the vector sequence to show they are ignored.

// File: rtl/pcv_pkg.sv
package pcv_pkg;
    typedef enum logic [1:0] {
        VS_LO  = 2'd0,
        VS_HI  = 2'd1,
        VS_RUN = 2'd2
    } vec_state_e;
endpackage

// File: rtl/pcv_vec_seq.sv
module pcv_vec_seq
    import pcv_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_ack,
    input  logic [BYTE_W-1:0]     rd_data,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  load_vec,
    output logic [2*BYTE_W-1:0]   vec_word,
    output logic                  running
);
    typedef struct packed {
        vec_state_e        st;
        logic [BYTE_W-1:0] lo;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        rd_req   = 1'b0;
        rd_addr  = '0;
        load_vec = 1'b0;
        case (seq_q.st)
            VS_LO: begin
                rd_req = 1'b1;
                if (rd_ack) begin
                    seq_d.lo = rd_data;
                    seq_d.st = VS_HI;
                end
            end
            VS_HI: begin
                rd_req  = 1'b1;
                rd_addr = ADDR_W'(1);
                if (rd_ack) begin
                    load_vec = 1'b1;
                    seq_d.st = VS_RUN;
                end
            end
            default: seq_d.st = VS_RUN;
        endcase
    end

    assign vec_word = {rd_data, seq_q.lo};
    assign running  = (seq_q.st == VS_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: VS_LO, lo: '0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/pcv_step.sv
module pcv_step #(
    parameter int ADDR_W  = 20,
    parameter int LEN_W   = 3,
    parameter int MIN_LEN = 1,
    parameter int MAX_LEN = 6
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] pc_next,
    output logic              len_ok
);
    localparam int PAD_W = ADDR_W - LEN_W;

    always_comb begin
        pc_next = pc_in + {{PAD_W{1'b0}}, len};
        len_ok  = (int'(len) >= MIN_LEN) && (int'(len) <= MAX_LEN);
    end
endmodule

// File: rtl/reset_vector_pc.sv
module reset_vector_pc #(
    parameter int ADDR_W  = 20,
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 3,
    parameter int MIN_LEN = 1,
    parameter int MAX_LEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [LEN_W-1:0]  fetch_len,
    input  logic              br_load,
    input  logic [ADDR_W-1:0] br_target,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic              pc_valid
);
    localparam int VEC_W = 2 * BYTE_W;
    localparam int HI_W  = ADDR_W - VEC_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              valid;
    } pc_s;

    pc_s pc_d, pc_q;

    logic              load_vec;
    logic [VEC_W-1:0]  vec_word;
    logic              running;
    logic [ADDR_W-1:0] pc_next;
    logic              len_ok;

    pcv_vec_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) vec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .load_vec (load_vec),
        .vec_word (vec_word),
        .running  (running)
    );

    pcv_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) step_i (
        .pc_in   (pc_q.pc),
        .len     (fetch_len),
        .pc_next (pc_next),
        .len_ok  (len_ok)
    );

    always_comb begin
        pc_d = pc_q;
        if (load_vec) begin
            pc_d.pc    = {{HI_W{1'b0}}, vec_word};
            pc_d.valid = 1'b1;
        end else if (running) begin
            if (br_load) begin
                pc_d.pc = br_target;
            end else if (fetch_en && len_ok) begin
                pc_d.pc = pc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '{pc: '0, valid: 1'b0};
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_out   = pc_q.pc;
    assign pc_valid = pc_q.valid;
endmodule

// File: rtl/reset_vector_pc_chk.sv
module reset_vector_pc_chk #(
    parameter int ADDR_W  = 20,
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 3,
    parameter int MIN_LEN = 1,
    parameter int MAX_LEN = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_en,
    input logic [LEN_W-1:0]  fetch_len,
    input logic              br_load,
    input logic [ADDR_W-1:0] br_target,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [BYTE_W-1:0] rd_data,
    input logic [ADDR_W-1:0] pc_out,
    input logic              pc_valid
);
    localparam int PAD_W = ADDR_W - LEN_W;
    localparam int VEC_W = 2 * BYTE_W;

    // R1
    seq_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!pc_valid && pc_out == '0));

    // R2
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr <= ADDR_W'(1)));

    // R3
    vec_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_valid) |-> (pc_out[ADDR_W-1:VEC_W] == '0));

    // R3
    vec_high_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_addr == ADDR_W'(1)) |=> (pc_valid && pc_out[VEC_W-1:BYTE_W] == $past(rd_data)));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && !br_load && fetch_en && int'(fetch_len) >= MIN_LEN && int'(fetch_len) <= MAX_LEN)
        |=> (pc_out == $past(pc_out) + {{PAD_W{1'b0}}, $past(fetch_len)}));

    // R5
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && !br_load && fetch_en && (int'(fetch_len) < MIN_LEN || int'(fetch_len) > MAX_LEN))
        |=> $stable(pc_out));

    // R6 R7
    branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && br_load) |=> (pc_out == $past(br_target)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && !br_load && !fetch_en) |=> $stable(pc_out));

    // R10
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> pc_valid);
endmodule

bind reset_vector_pc reset_vector_pc_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
) chk_i (.*);

// File: tb/reset_vector_pc_tb_top.sv
module reset_vector_pc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic [2:0]  fetch_len = '0;
    logic        br_load = 1'b0;
    logic [19:0] br_target = '0;
    logic        rd_req;
    logic [19:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = '0;
    logic [19:0] pc_out;
    logic        pc_valid;

    int checks = 0;
    int errors = 0;

    logic [7:0]  vlo, vhi;
    int          lat = 0;
    int          wait_cnt = 0;
    logic [19:0] addr_log [0:1];
    int          ack_n = 0;
    logic [19:0] exp_pc;

    always #4 clk = ~clk;

    reset_vector_pc dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_len(fetch_len),
        .br_load(br_load), .br_target(br_target), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .pc_out(pc_out), .pc_valid(pc_valid)
    );

    // memory model: one-cycle acknowledge after lat idle cycles
    always @(negedge clk) begin
        rd_ack <= 1'b0;
        if (rst_n && rd_req && !rd_ack) begin
            if (wait_cnt >= lat) begin
                rd_ack   <= 1'b1;
                rd_data  <= (rd_addr == 20'd0) ? vlo : vhi;
                wait_cnt <= 0;
                if (ack_n < 2) addr_log[ack_n] <= rd_addr;
                ack_n    <= ack_n + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic boot(input logic [7:0] lo, input logic [7:0] hi, input int l);
        int n;
        rst_n = 1'b0;
        vlo = lo; vhi = hi; lat = l;
        wait_cnt = 0; ack_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(pc_valid == 1'b0 && pc_out == 20'd0, "R1 reset state", pc_out, 20'd0);
        n = 0;
        // R9: strobes toggled during the vector sequence
        while (!pc_valid && n < 60) begin
            check(pc_out == 20'd0, "R1 zero during sequence", pc_out, 20'd0);
            br_load   = n[0];
            br_target = 20'hABCDE ^ 20'(n);
            fetch_en  = 1'b1;
            fetch_len = 3'd3;
            @(negedge clk);
            n++;
        end
        br_load = 1'b0; fetch_en = 1'b0;
        exp_pc = {4'h0, hi, lo};
        check(pc_valid == 1'b1, "R3 valid after vector", {19'd0, pc_valid}, 20'd1);
        check(pc_out == exp_pc, "R3 R9 vector loaded", pc_out, exp_pc);
        check(addr_log[0] == 20'd0, "R2 first read address", addr_log[0], 20'd0);
        check(addr_log[1] == 20'd1, "R2 second read address", addr_log[1], 20'd1);
    endtask

    task automatic step(input bit fe, input logic [2:0] len, input bit bl, input logic [19:0] tgt);
        fetch_en = fe; fetch_len = len; br_load = bl; br_target = tgt;
        @(negedge clk);
        fetch_en = 1'b0; br_load = 1'b0;
    endtask

    initial begin
        logic [7:0] los [0:3];
        logic [7:0] his [0:3];
        logic [19:0] starts [0:3];
        los[0] = 8'h00; his[0] = 8'h00;
        los[1] = 8'hFF; his[1] = 8'hFF;
        los[2] = 8'h34; his[2] = 8'h12;
        los[3] = 8'h5A; his[3] = 8'hA5;
        starts[0] = 20'h00000; starts[1] = 20'hFFFFE;
        starts[2] = 20'h7FFFB; starts[3] = 20'h12345;

        for (int v = 0; v < 4; v++) begin
            boot(los[v], his[v], v);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(pc_out == exp_pc, "R8 hold", pc_out, exp_pc);
                check(pc_valid == 1'b1, "R10 valid sticky", {19'd0, pc_valid}, 20'd1);
            end
        end

        for (int s = 0; s < 4; s++) begin
            for (int len = 0; len < 8; len++) begin
                step(1'b0, 3'd0, 1'b1, starts[s]);
                check(pc_out == starts[s], "R6 branch load", pc_out, starts[s]);
                step(1'b1, 3'(len), 1'b0, 20'd0);
                if (len >= 1 && len <= 6) begin
                    exp_pc = 20'((21'(starts[s]) + 21'(len)) & 21'hFFFFF);
                    check(pc_out == exp_pc, "R4 advance", pc_out, exp_pc);
                end else begin
                    exp_pc = starts[s];
                    check(pc_out == exp_pc, "R5 bad length ignored", pc_out, exp_pc);
                end
                step(1'b1, 3'(len), 1'b1, starts[(s+1)%4] ^ 20'(len));
                exp_pc = starts[(s+1)%4] ^ 20'(len);
                check(pc_out == exp_pc, "R7 branch wins", pc_out, exp_pc);
            end
        end

        // chain of advances across the wrap point
        step(1'b0, 3'd0, 1'b1, 20'hFFFF0);
        exp_pc = 20'hFFFF0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 3'((i % 6) + 1), 1'b0, 20'd0);
            exp_pc = exp_pc + 20'((i % 6) + 1);
            check(pc_out == exp_pc, "R4 wrap chain", pc_out, exp_pc);
        end
        check(pc_valid == 1'b1, "R10 valid at end", {19'd0, pc_valid}, 20'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule